// File: doc/BRIEF.md
# CPU Clock Rate-Change Sequencer

This block carries out the register sequence that moves a CPU clock domain from one frequency to another. It sits next to a clock control unit (CCU) and is the only master on a small register bus to it. A controller raises `evt_valid` with `evt_is_post` low before the domain PLL is retuned (the pre-change event) and again with `evt_is_post` high after the PLL has locked (the post-change event). The pre-change event also carries the current parent rate, the target parent rate and the alternate-source rate, all in Hz.

On a pre-change event the sequencer looks up the divider words for the target rate in an internal table. If running from the alternate source could overclock the core, it first programs a safe core divider. It then switches the core mux to the alternate source, waits until the CCU reports that the switch is done, and only then writes the full divider words. On a post-change event it switches the mux back to the main source and clears the core divider. Every wait polls a CCU status register and gives up after `TMO_CYC` reads.

States: `S_IDLE` accepts an event (to `S_SEARCH` for pre-change, to `S_RD_SRC` for post-change). `S_SEARCH` walks the table and goes to `S_RD_SRC` on a match or to `S_FIN` on a miss. `S_RD_SRC` goes to `S_RD_DIV1` (monitor source bit set), `S_RD_DIV0` (safe divider needed) or `S_SET_MUX`. `S_RD_DIV1` goes to `S_RD_DIV0` or `S_SET_MUX`. `S_RD_DIV0` goes to `S_WR_SAFE`. The states `S_WR_SAFE`, `S_SET_MUX`, `S_WR_DIV0` and `S_WR_DIV1` each go to `S_POLL`, and `S_POLL` returns to the state recorded for that wait. `S_FIN` pulses `done` and goes back to `S_IDLE`.

Register map on the bus (byte addresses, 32-bit data): `A_SRC`=0x00 holds the mux select at bit 16 and the monitor-source bit at bit 20. `A_MUXST`=0x04 holds the 3-bit mux status at bits 18:16, where 1 means main source and 2 means alternate source. `A_DIV0`=0x10 is divider word 0, with the core ratio in bits 2:0. `A_DIV1`=0x14 is divider word 1, with the monitor ratio in bits 6:4 and the copy ratio in bits 2:0. `A_DIV0ST`=0x18 and `A_DIV1ST`=0x1C are the divider status words, where non-zero means busy.

Rate table (index: kHz, divider word 0, divider word 1): 0: 1200000, 0x00012340, 0x163. 1: 1000000, 0x00012230, 0x152. 2: 800000, 0x00011120, 0x141. 3: 400000, 0x00001010, 0x130. 4: 0 (end marker).

Top module: `cpuclk_seq`

## Requirements
- R1: A pre-change event scans the table from index 0 upward and matches the first entry whose kHz value times 1000 equals `rate_new`. If the scan reaches an entry with kHz 0 or the end of the table first, `err_norate` is set, `done` pulses and no bus write takes place.
- R2: A safe core divider is applied on a pre-change event exactly when `rate_alt > rate_old` or `rate_old > rate_new`.
- R3: The safe divider is the smallest k with (k+1)·min(rate_old, rate_new) ≥ rate_alt. If that k would be 8 or more, the value 7 is used and `warn_divsat` is set.
- R4: The safe value is applied by a read-modify-write of `A_DIV0` that changes only bits 2:0. The block then waits until bits 2:0 of `A_DIV0ST` read 0, and the safe value is ORed into the full divider-0 word written later.
- R5: The pre-change write order is: optional safe write, then `A_SRC` with bit 16 set, then (after mux status bits 18:16 read 2) the full `A_DIV0`, then (after `A_DIV0ST` reads 0) `A_DIV1`, then a wait for `A_DIV1ST` to read 0.
- R6: When bit 20 of `A_SRC` is 1 on a pre-change event, `A_DIV1` is written with its current value ANDed with 0x77 instead of the table word.
- R7: A post-change event writes `A_SRC` with bit 16 cleared, waits for mux status 1, then writes `A_DIV0` with bits 2:0 cleared and the rest kept, and waits for bits 2:0 of `A_DIV0ST` to read 0.
- R8: A wait that is not satisfied after `TMO_CYC` status reads sets `err_timeout`, and the sequence carries on with its next step.
- R9: Events that arrive while `busy` is high are ignored.
- R10: `busy` rises in the cycle after an event is accepted and stays high up to and including the single-cycle `done` pulse. The flags hold until the next event is accepted.
- R11: There is at most one bus access per cycle, `bus_we` and `bus_re` are never high together, and read data is taken in the same cycle as `bus_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Event request, taken when idle |
| evt_is_post | input | 1 | 0 = pre-change, 1 = post-change |
| rate_old | input | RW | Current parent rate in Hz |
| rate_new | input | RW | Target parent rate in Hz |
| rate_alt | input | RW | Alternate-source rate in Hz |
| bus_rdata | input | DW | Read data from the CCU |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| err_norate | output | 1 | Target rate not found in the table |
| err_timeout | output | 1 | A status wait ran out |
| warn_divsat | output | 1 | Safe divider saturated at 7 |
| bus_addr | output | AW | Register address |
| bus_wdata | output | DW | Write data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |

## Verification
Pre-change events are tried in four forms: an upward step with a slow alternate source (no safe divider), a downward step (safe divider from the new rate), an upward step with a fast alternate source (safe divider from the old rate) and a step whose ratio exceeds the divider range. Comparing the write logs of these cases shows whether the safe-write condition, the ceiling arithmetic and the saturation are right. The CCU model delays its status bits, and each write is logged together with the mux and divider status at that moment, so a divider write issued before the switch has been confirmed shows up. A rate missing from the table, a set monitor-source bit, a post-change event, a stuck mux and events raised during a running sequence each cover one remaining path.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_SEARCH, S_RD_SRC, S_RD_DIV1, S_RD_DIV0, S_WR_SAFE,
        S_SET_MUX, S_POLL, S_WR_DIV0, S_WR_DIV1, S_FIN
    } seq_state_e;

    typedef enum logic [1:0] { PK_CORE, PK_MUX, PK_D0, PK_D1 } poll_kind_e;

    typedef struct packed {
        logic [31:0] khz;
        logic [31:0] div0;
        logic [31:0] div1;
    } rate_row_t;

    localparam int          TAB_N      = 5;
    localparam int          MUXSEL_BIT = 16;
    localparam int          MUXST_LSB  = 16;
    localparam int          HPMSRC_BIT = 20;
    localparam int          CORE_W     = 3;
    localparam logic [31:0] KEEP_MASK  = 32'h0000_0077;
    localparam logic [2:0]  MUX_MAIN   = 3'd1;
    localparam logic [2:0]  MUX_ALT    = 3'd2;

    function automatic rate_row_t tab_row(input logic [31:0] i);
        rate_row_t r;
        case (i)
            32'd0:   r = '{khz: 32'd1_200_000, div0: 32'h0001_2340, div1: 32'h0000_0163};
            32'd1:   r = '{khz: 32'd1_000_000, div0: 32'h0001_2230, div1: 32'h0000_0152};
            32'd2:   r = '{khz: 32'd800_000,   div0: 32'h0001_1120, div1: 32'h0000_0141};
            32'd3:   r = '{khz: 32'd400_000,   div0: 32'h0000_1010, div1: 32'h0000_0130};
            default: r = '{khz: 32'd0,         div0: 32'h0,          div1: 32'h0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/clkseq_ratetab.sv
module clkseq_ratetab
    import clkseq_pkg::*;
#(
    parameter int IW = 3
)(
    input  logic [IW-1:0] idx,
    output rate_row_t     row
);
    always_comb row = tab_row(32'(idx));
endmodule

// File: rtl/clkseq_safediv.sv
module clkseq_safediv #(
    parameter int RW     = 32,
    parameter int MAXDIV = 8,
    parameter int DVW    = $clog2(MAXDIV)
)(
    input  logic [RW-1:0]  old_rate,
    input  logic [RW-1:0]  new_rate,
    input  logic [RW-1:0]  alt_rate,
    output logic           need,
    output logic [DVW-1:0] safe,
    output logic           over
);
    localparam int PW = RW + DVW + 1;

    logic [RW-1:0]     floor_rate;
    logic [MAXDIV-1:0] fits;

    assign floor_rate = (old_rate < new_rate) ? old_rate : new_rate;
    assign need       = (alt_rate > old_rate) || (old_rate > new_rate);

    // fits[k]: dividing the alternate source by k+1 keeps it at or below the floor rate
    for (genvar k = 0; k < MAXDIV; k++) begin : g_fit
        assign fits[k] = (PW'(floor_rate) * PW'(k + 1)) >= PW'(alt_rate);
    end

    always_comb begin
        safe = DVW'(MAXDIV - 1);
        over = 1'b1;
        for (int k = MAXDIV - 1; k >= 0; k--) begin
            if (fits[k]) begin
                safe = DVW'(k);
                over = 1'b0;
            end
        end
    end
endmodule

// File: rtl/cpuclk_seq.sv
module cpuclk_seq
    import clkseq_pkg::*;
#(
    parameter int             AW       = 8,
    parameter int             DW       = 32,
    parameter int             RW       = 32,
    parameter int             MAXDIV   = 8,
    parameter int             TMO_CYC  = 2_000_000,
    parameter logic [AW-1:0]  A_SRC    = 8'h00,
    parameter logic [AW-1:0]  A_MUXST  = 8'h04,
    parameter logic [AW-1:0]  A_DIV0   = 8'h10,
    parameter logic [AW-1:0]  A_DIV1   = 8'h14,
    parameter logic [AW-1:0]  A_DIV0ST = 8'h18,
    parameter logic [AW-1:0]  A_DIV1ST = 8'h1C
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_valid,
    input  logic          evt_is_post,
    input  logic [RW-1:0] rate_old,
    input  logic [RW-1:0] rate_new,
    input  logic [RW-1:0] rate_alt,
    input  logic [DW-1:0] bus_rdata,
    output logic          busy,
    output logic          done,
    output logic          err_norate,
    output logic          err_timeout,
    output logic          warn_divsat,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_we,
    output logic          bus_re
);
    localparam int            IW       = $clog2(TAB_N);
    localparam int            DVW      = $clog2(MAXDIV);
    localparam int            TCW      = $clog2(TMO_CYC + 1);
    localparam int            PW       = RW + 10;
    localparam logic [DW-1:0] SEL_MASK = DW'(1) << MUXSEL_BIT;

    seq_state_e     st, nxt, ret_q;
    poll_kind_e     psel;
    logic [TCW-1:0] cnt;
    logic [IW-1:0]  idx;
    logic [RW-1:0]  old_q, new_q, alt_q;
    logic           post_q, hpm_q;
    logic [DW-1:0]  src_q, d0_q, d1_q, td0_q, td1_q;
    logic           err_q, tmo_q, warn_q;

    rate_row_t      row;
    logic           hit, last, settled;
    logic           need;
    logic [DVW-1:0] safe;
    logic           over;

    clkseq_ratetab #(.IW(IW)) u_tab (.idx(idx), .row(row));

    clkseq_safediv #(.RW(RW), .MAXDIV(MAXDIV)) u_safe (
        .old_rate(old_q), .new_rate(new_q), .alt_rate(alt_q),
        .need(need), .safe(safe), .over(over)
    );

    assign hit  = (PW'(row.khz) * PW'(1000)) == PW'(new_q);
    assign last = (idx == IW'(TAB_N - 1));

    always_comb begin
        case (psel)
            PK_CORE: settled = (bus_rdata[CORE_W-1:0] == '0);
            PK_MUX:  settled = (bus_rdata[MUXST_LSB +: 3] == (post_q ? MUX_MAIN : MUX_ALT));
            default: settled = (bus_rdata == '0);
        endcase
    end

    // next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:    if (evt_valid) nxt = evt_is_post ? S_RD_SRC : S_SEARCH;
            S_SEARCH:  if (row.khz == '0)  nxt = S_FIN;
                       else if (hit)       nxt = S_RD_SRC;
                       else if (last)      nxt = S_FIN;
            S_RD_SRC:  if (post_q)                     nxt = S_SET_MUX;
                       else if (bus_rdata[HPMSRC_BIT]) nxt = S_RD_DIV1;
                       else if (need)                  nxt = S_RD_DIV0;
                       else                            nxt = S_SET_MUX;
            S_RD_DIV1: nxt = need ? S_RD_DIV0 : S_SET_MUX;
            S_RD_DIV0: nxt = S_WR_SAFE;
            S_WR_SAFE, S_SET_MUX, S_WR_DIV0, S_WR_DIV1: nxt = S_POLL;
            S_POLL:    if (settled || cnt == TCW'(TMO_CYC - 1)) nxt = ret_q;
            S_FIN:     nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // state register and captured data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= S_IDLE;   ret_q <= S_IDLE;  psel <= PK_CORE;
            cnt <= '0;      idx <= '0;
            old_q <= '0;    new_q <= '0;      alt_q <= '0;
            post_q <= 1'b0; hpm_q <= 1'b0;
            src_q <= '0;    d0_q <= '0;       d1_q <= '0;
            td0_q <= '0;    td1_q <= '0;
            err_q <= 1'b0;  tmo_q <= 1'b0;    warn_q <= 1'b0;
        end else begin
            st <= nxt;
            case (st)
                S_IDLE: if (evt_valid) begin
                    old_q  <= rate_old;  new_q <= rate_new;  alt_q <= rate_alt;
                    post_q <= evt_is_post;
                    idx    <= '0;        hpm_q <= 1'b0;
                    err_q  <= 1'b0;      tmo_q <= 1'b0;      warn_q <= 1'b0;
                end
                S_SEARCH: begin
                    if (row.khz == '0)  err_q <= 1'b1;
                    else if (hit) begin
                        td0_q <= row.div0;
                        td1_q <= row.div1;
                    end
                    else if (last)      err_q <= 1'b1;
                    else                idx <= idx + 1'b1;
                end
                S_RD_SRC: begin
                    src_q <= bus_rdata;
                    hpm_q <= !post_q && bus_rdata[HPMSRC_BIT];
                end
                S_RD_DIV1: d1_q <= bus_rdata;
                S_RD_DIV0: d0_q <= bus_rdata;
                S_WR_SAFE: begin
                    psel  <= PK_CORE;
                    ret_q <= post_q ? S_FIN : S_SET_MUX;
                    cnt   <= '0;
                    if (!post_q) warn_q <= over;
                end
                S_SET_MUX: begin
                    psel  <= PK_MUX;
                    ret_q <= post_q ? S_RD_DIV0 : S_WR_DIV0;
                    cnt   <= '0;
                end
                S_WR_DIV0: begin psel <= PK_D0; ret_q <= S_WR_DIV1; cnt <= '0; end
                S_WR_DIV1: begin psel <= PK_D1; ret_q <= S_FIN;     cnt <= '0; end
                S_POLL: if (!settled) begin
                    if (cnt == TCW'(TMO_CYC - 1)) tmo_q <= 1'b1;
                    else                          cnt   <= cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (st != S_IDLE);
        done      = (st == S_FIN);
        bus_addr  = '0;
        bus_wdata = '0;
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        unique case (st)
            S_RD_SRC:  begin bus_re = 1'b1; bus_addr = A_SRC;  end
            S_RD_DIV1: begin bus_re = 1'b1; bus_addr = A_DIV1; end
            S_RD_DIV0: begin bus_re = 1'b1; bus_addr = A_DIV0; end
            S_WR_SAFE: begin
                bus_we    = 1'b1;
                bus_addr  = A_DIV0;
                bus_wdata = {d0_q[DW-1:CORE_W], post_q ? CORE_W'(0) : CORE_W'(safe)};
            end
            S_SET_MUX: begin
                bus_we    = 1'b1;
                bus_addr  = A_SRC;
                bus_wdata = post_q ? (src_q & ~SEL_MASK) : (src_q | SEL_MASK);
            end
            S_POLL: begin
                bus_re = 1'b1;
                case (psel)
                    PK_CORE: bus_addr = A_DIV0ST;
                    PK_MUX:  bus_addr = A_MUXST;
                    PK_D0:   bus_addr = A_DIV0ST;
                    default: bus_addr = A_DIV1ST;
                endcase
            end
            S_WR_DIV0: begin
                bus_we    = 1'b1;
                bus_addr  = A_DIV0;
                bus_wdata = td0_q | (need ? DW'(safe) : '0);
            end
            S_WR_DIV1: begin
                bus_we    = 1'b1;
                bus_addr  = A_DIV1;
                bus_wdata = hpm_q ? (d1_q & KEEP_MASK) : td1_q;
            end
            default: ;
        endcase
    end

    assign err_norate  = err_q;
    assign err_timeout = tmo_q;
    assign warn_divsat = warn_q;

    // assertions
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy)
        else $error("busy dropped before done");

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done))
        else $error("done not followed by idle");

    p_norate_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        err_norate |-> (!bus_we && !bus_re))
        else $error("bus access after rate miss");

    p_rw_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re))
        else $error("read and write in one cycle");

    p_div1_after_poll_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_DIV1) |-> ($past(st) == S_POLL))
        else $error("divider-1 write without a preceding wait");

endmodule

// File: tb/sim_cpuclk_seq.sv
`timescale 1ns/1ps
module sim_cpuclk_seq;
    localparam logic [7:0] A_SRC = 8'h00, A_MUXST = 8'h04, A_DIV0 = 8'h10,
                           A_DIV1 = 8'h14, A_DIV0ST = 8'h18, A_DIV1ST = 8'h1C;
    localparam int TMO = 40;

    logic clk = 1'b0, rst_n = 1'b0;
    logic evt_valid = 1'b0, evt_is_post = 1'b0;
    logic [31:0] rate_old = '0, rate_new = '0, rate_alt = '0;
    logic [31:0] bus_rdata;
    logic busy, done, err_norate, err_timeout, warn_divsat, bus_we, bus_re;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;

    always #2.5 clk = ~clk;

    cpuclk_seq #(.TMO_CYC(TMO)) u0 (
        .clk, .rst_n, .evt_valid, .evt_is_post, .rate_old, .rate_new, .rate_alt,
        .bus_rdata, .busy, .done, .err_norate, .err_timeout, .warn_divsat,
        .bus_addr, .bus_wdata, .bus_we, .bus_re
    );

    // clock control unit model with delayed status
    logic [31:0] m_src, m_div0, m_div1;
    logic [2:0]  m_mux, m_mtgt, m_mcnt, m_d0cnt, m_d1cnt;
    logic        m_load = 1'b0, m_stuck = 1'b0;
    logic [31:0] ld_src = '0, ld_div0 = '0, ld_div1 = '0;
    logic [2:0]  ld_mux = 3'd1;

    always_comb begin
        case (bus_addr)
            A_SRC:    bus_rdata = m_src;
            A_MUXST:  bus_rdata = {13'b0, m_mux, 16'b0};
            A_DIV0:   bus_rdata = m_div0;
            A_DIV1:   bus_rdata = m_div1;
            A_DIV0ST: bus_rdata = {31'b0, m_d0cnt != 0};
            A_DIV1ST: bus_rdata = {31'b0, m_d1cnt != 0};
            default:  bus_rdata = '0;
        endcase
    end

    always @(posedge clk) begin
        if (m_load) begin
            m_src <= ld_src; m_div0 <= ld_div0; m_div1 <= ld_div1; m_mux <= ld_mux;
            m_mtgt <= ld_mux; m_mcnt <= 0; m_d0cnt <= 0; m_d1cnt <= 0;
        end else begin
            if (m_mcnt != 0) begin
                m_mcnt <= m_mcnt - 1;
                if (m_mcnt == 1 && !m_stuck) m_mux <= m_mtgt;
            end
            if (m_d0cnt != 0) m_d0cnt <= m_d0cnt - 1;
            if (m_d1cnt != 0) m_d1cnt <= m_d1cnt - 1;
            if (bus_we) begin
                case (bus_addr)
                    A_SRC: begin
                        m_src <= bus_wdata; m_mux <= 3'd4; m_mcnt <= 3'd3;
                        m_mtgt <= bus_wdata[16] ? 3'd2 : 3'd1;
                    end
                    A_DIV0: begin m_div0 <= bus_wdata; m_d0cnt <= 3'd2; end
                    A_DIV1: begin m_div1 <= bus_wdata; m_d1cnt <= 3'd2; end
                    default: ;
                endcase
            end
        end
    end

    // write log with the status seen at each write
    logic [7:0]  lg_a   [16];
    logic [31:0] lg_d   [16];
    logic [2:0]  lg_mux [16];
    logic        lg_d0ok[16];
    int          lg_n = 0;
    int          n_chk = 0, n_err = 0;

    always @(negedge clk) begin
        if (rst_n && bus_we && lg_n < 16) begin
            lg_a[lg_n] = bus_addr;  lg_d[lg_n] = bus_wdata;
            lg_mux[lg_n] = m_mux;   lg_d0ok[lg_n] = (m_d0cnt == 0);
            lg_n = lg_n + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_w(input string tag, input int i, input logic [7:0] a, input logic [31:0] d);
        chk({tag, " addr"}, 32'(lg_a[i]), 32'(a));
        chk({tag, " data"}, lg_d[i], d);
    endtask

    task automatic load(input logic [31:0] s, input logic [31:0] d0, input logic [31:0] d1,
                        input logic [2:0] mx, input logic stuck);
        @(negedge clk);
        ld_src = s; ld_div0 = d0; ld_div1 = d1; ld_mux = mx; m_stuck = stuck; m_load = 1'b1;
        @(negedge clk);
        m_load = 1'b0;
        lg_n = 0;
    endtask

    task automatic wait_done(input string tag);
        int k = 0;
        while (!done && k < 2000) begin @(negedge clk); k++; end
        chk({tag, " done seen"}, 32'(done), 32'd1);
    endtask

    task automatic run_evt(input string tag, input logic post, input logic [31:0] o,
                           input logic [31:0] n, input logic [31:0] a);
        @(negedge clk);
        evt_is_post = post; rate_old = o; rate_new = n; rate_alt = a; evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
        chk({tag, " busy after accept"}, 32'(busy), 32'd1);
        wait_done(tag);
    endtask

    task automatic t_reset;
        chk("R10 reset busy", 32'(busy), 0);
        chk("R10 reset done", 32'(done), 0);
        chk("R11 reset we/re", {30'b0, bus_we, bus_re}, 0);
        chk("R10 reset flags", {29'b0, err_norate, err_timeout, warn_divsat}, 0);
    endtask

    task automatic t_up_nosafe;
        load(32'h0, 32'h0000_0005, 32'h0, 3'd1, 1'b0);
        run_evt("R2 up", 1'b0, 32'd800_000_000, 32'd1_000_000_000, 32'd400_000_000);
        chk("R2 no safe write count", lg_n, 3);
        chk_w("R5 up w0 mux", 0, A_SRC, 32'h0001_0000);
        chk_w("R5 up w1 div0", 1, A_DIV0, 32'h0001_2230);
        chk_w("R5 up w2 div1", 2, A_DIV1, 32'h0000_0152);
        chk("R5 div0 after mux=2", 32'(lg_mux[1]), 32'd2);
        chk("R5 div1 after div0 settled", 32'(lg_d0ok[2]), 32'd1);
        chk("R3 no warn", 32'(warn_divsat), 0);
    endtask

    task automatic t_down_safe;
        load(32'h0, 32'h00AB_0006, 32'h0, 3'd1, 1'b0);
        run_evt("R4 down", 1'b0, 32'd1_000_000_000, 32'd400_000_000, 32'd800_000_000);
        chk("R2 down write count", lg_n, 4);
        chk_w("R4 safe field only", 0, A_DIV0, 32'h00AB_0001);
        chk_w("R5 down mux", 1, A_SRC, 32'h0001_0000);
        chk("R4 mux after safe settled", 32'(lg_d0ok[1]), 32'd1);
        chk_w("R4 safe ORed into div0", 2, A_DIV0, 32'h0000_1011);
        chk("R5 down div0 after mux=2", 32'(lg_mux[2]), 32'd2);
        chk_w("R5 down div1", 3, A_DIV1, 32'h0000_0130);
    endtask

    task automatic t_alt_fast;
        load(32'h0, 32'h0, 32'h0, 3'd1, 1'b0);
        run_evt("R3 altfast", 1'b0, 32'd400_000_000, 32'd800_000_000, 32'd1_000_000_000);
        chk("R2 altfast count", lg_n, 4);
        chk_w("R3 ceil value 2", 0, A_DIV0, 32'h0000_0002);
        chk_w("R3 div0 with safe", 2, A_DIV0, 32'h0001_1122);
        chk("R3 altfast no warn", 32'(warn_divsat), 0);
    endtask

    task automatic t_warn;
        load(32'h0, 32'h0000_0000, 32'h0, 3'd1, 1'b0);
        run_evt("R3 sat", 1'b0, 32'd100_000_000, 32'd400_000_000, 32'd1_200_000_000);
        chk("R3 warn set", 32'(warn_divsat), 32'd1);
        chk_w("R3 saturated safe", 0, A_DIV0, 32'h0000_0007);
        chk_w("R3 saturated in div0", 2, A_DIV0, 32'h0000_1017);
    endtask

    task automatic t_hpm;
        load(32'h0010_0000, 32'h0, 32'hABCD_1234, 3'd1, 1'b0);
        run_evt("R6 hpm", 1'b0, 32'd800_000_000, 32'd1_200_000_000, 32'd400_000_000);
        chk("R6 count", lg_n, 3);
        chk_w("R6 mux keeps bit20", 0, A_SRC, 32'h0011_0000);
        chk_w("R6 div0 table", 1, A_DIV0, 32'h0001_2340);
        chk_w("R6 div1 kept fields", 2, A_DIV1, 32'h0000_0034);
    endtask

    task automatic t_norate;
        load(32'h0, 32'h0, 32'h0, 3'd1, 1'b0);
        run_evt("R1 miss", 1'b0, 32'd800_000_000, 32'd123_000_000, 32'd400_000_000);
        chk("R1 err_norate", 32'(err_norate), 32'd1);
        chk("R1 no writes", lg_n, 0);
        run_evt("R1 hit clears", 1'b0, 32'd800_000_000, 32'd1_000_000_000, 32'd400_000_000);
        chk("R10 flag cleared on accept", 32'(err_norate), 0);
    endtask

    task automatic t_post;
        load(32'h0011_0000, 32'h00CC_0003, 32'h0, 3'd2, 1'b0);
        run_evt("R7 post", 1'b1, 32'd0, 32'd0, 32'd0);
        chk("R7 count", lg_n, 2);
        chk_w("R7 mux back", 0, A_SRC, 32'h0010_0000);
        chk_w("R7 core cleared", 1, A_DIV0, 32'h00CC_0000);
        chk("R7 div0 after mux=1", 32'(lg_mux[1]), 32'd1);
        chk("R7 no error", {30'b0, err_norate, err_timeout}, 0);
    endtask

    task automatic t_timeout;
        load(32'h0, 32'h0, 32'h0, 3'd1, 1'b1);
        run_evt("R8 stuck", 1'b0, 32'd800_000_000, 32'd1_000_000_000, 32'd400_000_000);
        chk("R8 err_timeout", 32'(err_timeout), 32'd1);
        chk("R8 sequence continued", lg_n, 3);
        chk_w("R8 div1 still written", 2, A_DIV1, 32'h0000_0152);
    endtask

    task automatic t_busy_ignore;
        load(32'h0, 32'h0, 32'h0, 3'd1, 1'b0);
        @(negedge clk);
        evt_is_post = 1'b0; rate_old = 32'd800_000_000; rate_new = 32'd1_000_000_000;
        rate_alt = 32'd400_000_000; evt_valid = 1'b1;
        @(negedge clk);
        evt_is_post = 1'b1; rate_new = 32'd400_000_000;
        repeat (4) @(negedge clk);
        evt_valid = 1'b0;
        wait_done("R9 busy");
        repeat (6) @(negedge clk);
        chk("R9 no second sequence", 32'(busy), 0);
        chk("R9 only first writes", lg_n, 3);
        chk_w("R9 div0 from first event", 1, A_DIV0, 32'h0001_2230);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_up_nosafe();
        t_down_safe();
        t_alt_fast();
        t_warn();
        t_hpm();
        t_norate();
        t_post();
        t_timeout();
        t_busy_ignore();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(200_000 * 5);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule